// File: doc/BRIEF.md
# Dual-Strobe Mode-Select Shift Register

This block is a four-stage register that either captures a parallel word or shifts right by one place, with each action triggered by its own strobe input. A mode select chooses which strobe matters: with the mode high, a falling edge on the load strobe captures the parallel word; with the mode low, a falling edge on the shift strobe moves every stage up by one place, takes the serial input into stage 0 and shows stage 3 on the serial output. A falling edge on the strobe that does not belong to the current mode is ignored. The four stage outputs are always driven.

Both strobes are treated as slow asynchronous signals. Each one passes through a synchroniser chain clocked by the system clock, and a falling edge is turned into a single-cycle internal pulse. A select input replaces the external parallel word with a rotated copy of the register's own outputs. A load in that setting shifts the contents left by one place and wraps the top stage around. Pairing a serialiser instance with a deserialiser instance gives a simple serial link.

Top module: `dual_strobe_shift_reg`

## Requirements
- R1: On a clock edge with rst_n low, q becomes 4'b0000.
- R2: With mode_sel high and left_sel low, a falling edge on load_strobe sets q to par_in (q[i] takes par_in[i]).
- R3: With mode_sel low, a falling edge on shift_strobe sets q[0] to ser_in and q[i+1] to the old q[i].
- R4: ser_out always equals q[3].
- R5: A falling edge on load_strobe while mode_sel is low, or on shift_strobe while mode_sel is high, leaves q unchanged.
- R6: With mode_sel high and left_sel high, a falling edge on load_strobe loads the rotated contents: q[0] gets old q[1], q[1] gets old q[2], q[2] gets old q[3] and q[3] gets old q[0]. par_in has no effect.
- R7: q changes on the third rising clock edge after a strobe is first sampled low, and not on the second. A strobe held low, or a rising strobe, causes no further change.
- R8: A strobe that is already low when reset is released does not count as a falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_sel | input | 1 | 1 = load mode, 0 = shift-right mode |
| shift_strobe | input | 1 | Shift trigger, acts on its falling edge in shift mode |
| load_strobe | input | 1 | Load trigger, acts on its falling edge in load mode |
| left_sel | input | 1 | 1 = load the rotated register contents instead of par_in |
| ser_in | input | 1 | Serial data entering stage 0 |
| par_in | input | 4 | Parallel word, bit i goes to stage i |
| q | output | 4 | Stage outputs, bit i is stage i |
| ser_out | output | 1 | Serial output, equal to stage 3 |

## Verification
The assertions check the update rules on every cycle against the internal edge pulses: load, right shift and left rotation, hold whenever no matching edge occurs, single-cycle edge pulses, and clearing on reset. Only the bench scenarios can show the timing from a strobe pin to the outputs. These scenarios cover the exact cycle of the update, no repeat for a held strobe, no false edge when reset is released with a strobe low, and the serial output following stage 3 over several bit patterns.

// File: rtl/dssr_pkg.sv
// Shared definitions for the dual-strobe shift register.
// Assumes: the register width is at least 2.
package dssr_pkg;
    localparam int unsigned DSSR_WIDTH = 4;
    localparam int unsigned DSSR_SYNC  = 2;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } dssr_op_e;
endpackage

// File: rtl/dssr_edge_sync.sv
// Synchroniser chain plus falling-edge detector for one strobe input.
// Assumes: strobe_in is asynchronous to clk and stays in each level for
// several clock periods. The chain resets to 0, so a strobe that is low
// when reset is released does not give a falling edge.
module dssr_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_in,
    output logic fall_pulse
);
    localparam int unsigned LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              prev;

    // Move the strobe through the chain and keep the last synced level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '0;
            prev  <= 1'b0;
        end else begin
            chain <= {chain[STAGES-2:0], strobe_in};
            prev  <= chain[LAST];
        end
    end

    // One-cycle pulse when the synced level goes from 1 to 0.
    always_comb begin
        fall_pulse = prev & ~chain[LAST];
    end
endmodule

// File: rtl/dssr_load_mux.sv
// Picks the word for a load: the external parallel word, or the current
// contents rotated down by one stage (stage i takes stage i+1, the top
// stage takes stage 0). A load of the rotated word is a left shift.
module dssr_load_mux #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             left_sel,
    input  logic [WIDTH-1:0] par_in,
    input  logic [WIDTH-1:0] q_cur,
    output logic [WIDTH-1:0] load_word
);
    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            localparam int unsigned SRC = (i + 1) % WIDTH;
            // Select the source for stage i.
            always_comb begin
                load_word[i] = left_sel ? q_cur[SRC] : par_in[i];
            end
        end
    endgenerate
endmodule

// File: rtl/dssr_core.sv
// Holds the register stages and applies one of three operations per cycle.
// Assumes: load_fire and shift_fire are single-cycle pulses in the clk domain.
module dssr_core
    import dssr_pkg::*;
#(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_sel,
    input  logic             load_fire,
    input  logic             shift_fire,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] load_word,
    output logic [WIDTH-1:0] q
);
    dssr_op_e op;

    // Decode the operation: each pulse counts only in its own mode.
    always_comb begin
        if (mode_sel && load_fire)
            op = OP_LOAD;
        else if (!mode_sel && shift_fire)
            op = OP_SHIFT;
        else
            op = OP_HOLD;
    end

    // Update the stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            case (op)
                OP_LOAD:  q <= load_word;
                OP_SHIFT: q <= {q[WIDTH-2:0], ser_in};
                default:  q <= q;
            endcase
        end
    end
endmodule

// File: rtl/dual_strobe_shift_reg.sv
// Top level: two strobe synchronisers, the load-word mux and the register.
// Assumes: mode_sel, left_sel, ser_in and par_in are steady in the clk
// domain while a strobe edge is being handled.
module dual_strobe_shift_reg
    import dssr_pkg::*;
#(
    parameter int unsigned WIDTH       = DSSR_WIDTH,
    parameter int unsigned SYNC_STAGES = DSSR_SYNC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_sel,
    input  logic             shift_strobe,
    input  logic             load_strobe,
    input  logic             left_sel,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q,
    output logic             ser_out
);
    logic             shift_fall;
    logic             load_fall;
    logic [WIDTH-1:0] load_word;

    dssr_edge_sync #(.STAGES(SYNC_STAGES)) u_shift_sync (
        .clk(clk), .rst_n(rst_n), .strobe_in(shift_strobe), .fall_pulse(shift_fall)
    );

    dssr_edge_sync #(.STAGES(SYNC_STAGES)) u_load_sync (
        .clk(clk), .rst_n(rst_n), .strobe_in(load_strobe), .fall_pulse(load_fall)
    );

    dssr_load_mux #(.WIDTH(WIDTH)) u_mux (
        .left_sel(left_sel), .par_in(par_in), .q_cur(q), .load_word(load_word)
    );

    dssr_core #(.WIDTH(WIDTH)) u_core (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .load_fire(load_fall), .shift_fire(shift_fall),
        .ser_in(ser_in), .load_word(load_word), .q(q)
    );

    // The serial output is the top stage.
    always_comb begin
        ser_out = q[WIDTH-1];
    end
endmodule

// File: rtl/dssr_checker.sv
// Checks the update rules of dual_strobe_shift_reg each cycle, using the
// internal edge pulses. Attached by the bind statement at the end.
module dssr_checker #(
    parameter int unsigned WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_sel,
    input logic             left_sel,
    input logic             ser_in,
    input logic [WIDTH-1:0] par_in,
    input logic [WIDTH-1:0] q,
    input logic             shift_fall,
    input logic             load_fall
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> q == '0);

    p_load_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_fall && mode_sel && !left_sel) |=> q == $past(par_in));

    p_shift_right_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_fall && !mode_sel) |=> q == {$past(q[WIDTH-2:0]), $past(ser_in)});

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(load_fall && mode_sel) && !(shift_fall && !mode_sel)) |=> $stable(q));

    p_rotate_left_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (load_fall && mode_sel && left_sel) |=> q == {$past(q[0]), $past(q[WIDTH-1:1])});

    p_shift_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        shift_fall |=> !shift_fall);

    p_load_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_fall |=> !load_fall);
endmodule

bind dual_strobe_shift_reg dssr_checker #(.WIDTH(WIDTH)) u_dssr_checker (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .left_sel(left_sel),
    .ser_in(ser_in), .par_in(par_in), .q(q),
    .shift_fall(shift_fall), .load_fall(load_fall)
);

// File: tb/tb_dual_strobe_shift_reg.sv
// Directed bench: one task per scenario, each checks its own results.
module tb_dual_strobe_shift_reg;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       mode_sel;
    logic       shift_strobe;
    logic       load_strobe;
    logic       left_sel;
    logic       ser_in;
    logic [3:0] par_in;
    logic [3:0] q;
    logic       ser_out;

    int checks = 0;
    int errors = 0;
    logic [3:0] exp_q;

    always #5 clk = ~clk;

    dual_strobe_shift_reg dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .shift_strobe(shift_strobe), .load_strobe(load_strobe),
        .left_sel(left_sel), .ser_in(ser_in), .par_in(par_in),
        .q(q), .ser_out(ser_out)
    );

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, expv);
        end
    endtask

    task automatic check_q(input string req);
        check(req, q, exp_q);
        check("R4", {3'b000, ser_out}, {3'b000, exp_q[3]});
    endtask

    // Full strobe pulse: low long enough to be seen, then back high.
    task automatic pulse(input bit is_load);
        if (is_load) load_strobe = 1'b0; else shift_strobe = 1'b0;
        repeat (4) @(negedge clk);
        if (is_load) load_strobe = 1'b1; else shift_strobe = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        exp_q = 4'b0000;
        check_q("R1");
    endtask

    task automatic t_load(input logic [3:0] w);
        mode_sel = 1'b1; left_sel = 1'b0; par_in = w;
        pulse(1'b1);
        exp_q = w;
        check_q("R2");
    endtask

    task automatic t_shift(input logic [3:0] bits);
        mode_sel = 1'b0;
        for (int i = 0; i < 4; i++) begin
            ser_in = bits[i];
            pulse(1'b0);
            exp_q = {exp_q[2:0], bits[i]};
            check_q("R3");
        end
    endtask

    task automatic t_wrong_strobe();
        mode_sel = 1'b0; par_in = ~exp_q; left_sel = 1'b0;
        pulse(1'b1);
        check_q("R5");
        mode_sel = 1'b1; ser_in = ~exp_q[0];
        pulse(1'b0);
        check_q("R5");
    endtask

    task automatic t_rotate();
        mode_sel = 1'b1; left_sel = 1'b1; par_in = 4'b0000;
        for (int i = 0; i < 2; i++) begin
            pulse(1'b1);
            exp_q = {exp_q[0], exp_q[3:1]};
            check_q("R6");
        end
        left_sel = 1'b0;
    endtask

    task automatic t_latency();
        mode_sel = 1'b1; left_sel = 1'b0; par_in = ~exp_q;
        load_strobe = 1'b0;
        @(posedge clk);   // first sample low
        @(posedge clk);   // second edge: no change yet
        @(negedge clk);
        check_q("R7");
        @(negedge clk);   // third edge passed
        exp_q = par_in;
        check_q("R7");
        par_in = ~par_in;
        repeat (6) @(negedge clk);  // held low: no more updates
        check_q("R7");
        load_strobe = 1'b1;
        repeat (6) @(negedge clk);  // rising edge: no update
        check_q("R7");
    endtask

    task automatic t_low_at_reset();
        mode_sel = 1'b1; left_sel = 1'b0; par_in = 4'b1111;
        load_strobe = 1'b0;
        do_reset();
        repeat (6) @(negedge clk);
        exp_q = 4'b0000;
        check_q("R8");
        load_strobe = 1'b1;
        repeat (4) @(negedge clk);
        check_q("R8");
    endtask

    initial begin
        rst_n = 1'b0; mode_sel = 1'b0; shift_strobe = 1'b1; load_strobe = 1'b1;
        left_sel = 1'b0; ser_in = 1'b0; par_in = 4'b0000; exp_q = 4'b0000;
        @(negedge clk);
        do_reset();
        repeat (4) @(negedge clk);
        t_reset();
        t_load(4'b1010);
        t_load(4'b0101);
        t_shift(4'b1101);
        t_shift(4'b0010);
        t_wrong_strobe();
        t_load(4'b1011);
        t_rotate();
        t_latency();
        t_low_at_reset();
        t_load(4'b0110);
        t_reset_mid();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    task automatic t_reset_mid();
        do_reset();
        exp_q = 4'b0000;
        check_q("R1");
    endtask

    initial begin
        #2000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule